// File: doc/BRIEF.md
# GPIO Port Edge Interrupt Controller

This block turns level changes on an eight-pin general purpose input port into interrupt requests. Each pin is brought into the clock domain through a two-flop synchronizer. The synchronized level is compared with its value from the cycle before to find rising and falling edges. Software chooses, for every pin separately, whether rising edges, falling edges, both or neither are of interest. A qualifying edge sets a sticky status bit, and that bit stays set until software clears it by writing a one to it.

A ninth interrupt source serves noisy inputs. A selector routes any one pin through a glitch filter, and the filter only accepts a new level once that level has held for a programmable number of clock cycles. The filtered level has its own edge-mode field and its own status bit. The combined interrupt line is high whenever any status bit is set.

Software reaches the block through a minimal register port. Select 0 holds the configuration word. Select 1 reads the status bits and clears them by write-one-to-clear. Reads are combinational.

Top module: `port_edge_irq`

## Requirements
- R1: After reset, the configuration word reads 0, the status reads 0 and `irq` is low.
- R2: A write with `wrSel`=0 stores `wrData[20:0]` as the configuration word. Reading with `rdSel`=0 returns it, and bits 31:21 read as zero.
- R3: Pin n's edge mode is held in configuration bits [2n+1:2n]. The codes are 0 = off, 1 = rising, 2 = falling and 3 = both. A matching edge on pin n sets status bit n, which reads as bit n of `rdData` when `rdSel`=1.
- R4: A status bit for a pin edge becomes visible after the third rising clock edge that follows the input change: two synchronizer stages, then the detect-and-latch stage.
- R5: A set status bit stays set, whatever the pin does afterwards, until software clears it.
- R6: A write with `wrSel`=1 clears every status bit whose `wrData` bit is 1 and leaves the bits written with 0 unchanged.
- R7: If a qualifying edge and a clear of the same status bit happen in the same cycle, the bit stays set.
- R8: `irq` is high exactly when at least one of the nine status bits is set.
- R9: Configuration bits 20:18 select the pin routed through the glitch filter. Bits 17:16 hold the filtered source's edge mode, in the same encoding as R3. The filtered source reports in status bit 8.
- R10: The filter accepts a new level only after the synchronized selected pin has held it for `FILT_CYCLES` consecutive cycles, so shorter pulses are dropped. An accepted edge sets status bit 8 at the (`FILT_CYCLES`+2)-th rising clock edge after the pin changes.
- R11: Changing the filter selector reloads the filter from the newly selected pin, and the switch by itself never sets status bit 8.
- R12: A source whose edge mode is 0 never sets its status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Asynchronous pin levels |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = configuration, 1 = status clear |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read target: 0 = configuration, 1 = status |
| rdData | output | 32 | Read data, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The main sweep walks every pin through all four edge modes. Each pin gets a rising transition and then a falling one, so that a wrong field offset, swapped codes or crosstalk between pins shows up as a wrong bit. The filter is driven with pulses one cycle shorter than the threshold and exactly at the threshold, which pins the threshold down to a single cycle. It also sees edges on an unselected pin and a selector switch between pins at different levels, which separates a proper reload from a spurious event. Clears are issued on their own, with partial masks, and in the same cycle as a new edge, which tells set priority apart from clear priority.

// File: rtl/port_edge_irq_pkg.sv
package port_edge_irq_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edgeMode_t;

  typedef struct packed {
    logic statusClr;   // status write-one-to-clear strobe
    logic filtReload;  // selector changed: reload filter
  } ctrlStrobes_t;

  function automatic logic edgeHit(input logic [1:0] mode, input logic rise, input logic fall);
    logic hit;
    case (edgeMode_t'(mode))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_ANY:  hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/port_edge_glitch_filter.sv
module port_edge_glitch_filter #(
  parameter int unsigned FILT_CYCLES = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic sample,
  input  logic reload,
  output logic level,
  output logic riseEv,
  output logic fallEv
);
  localparam int unsigned CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;
  logic differs;
  logic commit;

  assign differs = (sample != level);
  assign commit  = !reload && differs && (holdCnt == LAST);
  assign riseEv  = commit && sample;
  assign fallEv  = commit && !sample;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level   <= 1'b0;
      holdCnt <= '0;
    end else if (reload) begin
      level   <= sample;
      holdCnt <= '0;
    end else if (commit) begin
      level   <= sample;
      holdCnt <= '0;
    end else if (differs) begin
      holdCnt <= holdCnt + 1'b1;
    end else begin
      holdCnt <= '0;
    end
  end
endmodule

// File: rtl/port_edge_irq_ctrl.sv
module port_edge_irq_ctrl
  import port_edge_irq_pkg::*;
#(
  parameter int unsigned PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [31:0]          wrData,
  input  logic                 rdSel,
  input  logic [PIN_COUNT:0]   statusQ,
  output logic [2*PIN_COUNT+2+$clog2(PIN_COUNT)-1:0] cfgWord,
  output logic [PIN_COUNT:0]   clrMask,
  output ctrlStrobes_t         strobes,
  output logic [31:0]          rdData
);
  localparam int unsigned SEL_W = $clog2(PIN_COUNT);
  localparam int unsigned CFG_W = 2*PIN_COUNT + 2 + SEL_W;

  logic cfgLoad;
  logic selDiffers;
  logic reloadQ;
  logic unusedHi;

  assign cfgLoad    = wrEn && !wrSel;
  assign selDiffers = wrData[CFG_W-1 -: SEL_W] != cfgWord[CFG_W-1 -: SEL_W];
  assign unusedHi   = ^wrData[31:CFG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWord <= '0;
      reloadQ <= 1'b0;
    end else begin
      reloadQ <= cfgLoad && selDiffers;
      if (cfgLoad) cfgWord <= wrData[CFG_W-1:0];
    end
  end

  always_comb begin
    strobes.statusClr  = wrEn && wrSel;
    strobes.filtReload = reloadQ;
    clrMask            = wrData[PIN_COUNT:0];
    rdData             = rdSel ? 32'(statusQ) : 32'(cfgWord);
  end
endmodule

// File: rtl/port_edge_irq_dp.sv
module port_edge_irq_dp
  import port_edge_irq_pkg::*;
#(
  parameter int unsigned PIN_COUNT   = 8,
  parameter int unsigned FILT_CYCLES = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic [2*PIN_COUNT+2+$clog2(PIN_COUNT)-1:0] cfgWord,
  input  logic [PIN_COUNT:0]   clrMask,
  input  ctrlStrobes_t         strobes,
  output logic [PIN_COUNT:0]   statusQ
);
  localparam int unsigned SEL_W = $clog2(PIN_COUNT);
  localparam int unsigned CFG_W = 2*PIN_COUNT + 2 + SEL_W;
  localparam int unsigned FLT_MODE_LSB = 2*PIN_COUNT;

  logic [PIN_COUNT-1:0] syncA;
  logic [PIN_COUNT-1:0] pinSync;
  logic [PIN_COUNT-1:0] pinPrev;
  logic [PIN_COUNT-1:0] pinHit;
  logic [SEL_W-1:0]     fltSel;
  logic                 fltSample;
  logic                 fltLevel;
  logic                 fltRise;
  logic                 fltFall;
  logic                 fltHit;
  logic [PIN_COUNT:0]   setVec;
  logic [PIN_COUNT:0]   keepMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= '0;
      pinSync <= '0;
      pinPrev <= '0;
    end else begin
      syncA   <= pinIn;
      pinSync <= syncA;
      pinPrev <= pinSync;
    end
  end

  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
    assign pinHit[n] = edgeHit(cfgWord[2*n+1:2*n],
                               pinSync[n] & ~pinPrev[n],
                               ~pinSync[n] & pinPrev[n]);
  end

  assign fltSel    = cfgWord[CFG_W-1 -: SEL_W];
  assign fltSample = pinSync[fltSel];

  port_edge_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) i_filter (
    .clk    (clk),
    .rstN   (rstN),
    .sample (fltSample),
    .reload (strobes.filtReload),
    .level  (fltLevel),
    .riseEv (fltRise),
    .fallEv (fltFall)
  );

  assign fltHit   = edgeHit(cfgWord[FLT_MODE_LSB+1:FLT_MODE_LSB], fltRise, fltFall);
  assign setVec   = {fltHit, pinHit};
  assign keepMask = strobes.statusClr ? ~clrMask : '1;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & keepMask) | setVec;
  end

  logic unusedLevel;
  assign unusedLevel = fltLevel;
endmodule

// File: rtl/port_edge_irq.sv
module port_edge_irq
  import port_edge_irq_pkg::*;
#(
  parameter int unsigned PIN_COUNT   = 8,
  parameter int unsigned FILT_CYCLES = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic                 wrEn,
  input  logic                 wrSel,
  input  logic [31:0]          wrData,
  input  logic                 rdSel,
  output logic [31:0]          rdData,
  output logic                 irq
);
  localparam int unsigned SEL_W = $clog2(PIN_COUNT);
  localparam int unsigned CFG_W = 2*PIN_COUNT + 2 + SEL_W;

  logic [CFG_W-1:0]   cfgWord;
  logic [PIN_COUNT:0] statusQ;
  logic [PIN_COUNT:0] clrMask;
  ctrlStrobes_t       strobes;

  port_edge_irq_ctrl #(.PIN_COUNT(PIN_COUNT)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .rdSel   (rdSel),
    .statusQ (statusQ),
    .cfgWord (cfgWord),
    .clrMask (clrMask),
    .strobes (strobes),
    .rdData  (rdData)
  );

  port_edge_irq_dp #(.PIN_COUNT(PIN_COUNT), .FILT_CYCLES(FILT_CYCLES)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .cfgWord (cfgWord),
    .clrMask (clrMask),
    .strobes (strobes),
    .statusQ (statusQ)
  );

  assign irq = |statusQ;
endmodule

// File: rtl/port_edge_irq_chk.sv
module port_edge_irq_chk #(
  parameter int unsigned PIN_COUNT = 8,
  parameter int unsigned CFG_W     = 21
) (
  input logic               clk,
  input logic               rstN,
  input logic [CFG_W-1:0]   cfgWord,
  input logic [PIN_COUNT:0] statusQ,
  input logic               wrEn,
  input logic               wrSel,
  input logic [31:0]        wrData
);
  localparam int unsigned SEL_W = $clog2(PIN_COUNT);

  logic [PIN_COUNT:0] enMask;
  logic [PIN_COUNT:0] clrReq;
  logic [SEL_W-1:0]   selNow;

  always_comb begin
    for (int n = 0; n <= PIN_COUNT; n++) enMask[n] = cfgWord[2*n +: 2] != 2'd0;
    clrReq = (wrEn && wrSel) ? wrData[PIN_COUNT:0] : '0;
    selNow = cfgWord[CFG_W-1 -: SEL_W];
  end

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statusQ) & ~$past(clrReq) & ~statusQ) == '0));

  p_cfg_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> (cfgWord == $past(wrData[CFG_W-1:0])));

  p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & ~$past(enMask)) == '0));

  p_switch_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (selNow != $past(selNow)) |=> !$rose(statusQ[PIN_COUNT]));
endmodule

bind port_edge_irq port_edge_irq_chk #(.PIN_COUNT(PIN_COUNT), .CFG_W(CFG_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWord (cfgWord),
  .statusQ (statusQ),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .wrData  (wrData)
);

// File: tb/test_port_edge_irq.sv
`timescale 1ns/1ps
module test_port_edge_irq;
  localparam int FC = 5;
  localparam time CLK_P = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pinIn = '0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  port_edge_irq #(.PIN_COUNT(8), .FILT_CYCLES(FC)) i_port_edge_irq (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic sel, input logic [31:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rdReg(input logic sel, output logic [31:0] v);
    rdSel = sel;
    #1;
    v = rdData;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic checkStatus(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rdReg(1'b1, v);
    check(tag, v, exp);
    check({tag, " irq R8"}, {31'd0, irq}, {31'd0, exp != 0});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(1'b0, v); check("R1 cfg", v, 32'h0);
    checkStatus("R1 status", 32'h0);

    // R2 register store and unused bits
    wrReg(1'b0, 32'hFFFF_FFFF);
    rdReg(1'b0, v); check("R2 readback", v, 32'h001F_FFFF);
    wrReg(1'b0, 32'hA5A5_5A5A);
    rdReg(1'b0, v); check("R2 pattern", v, 32'h0005_5A5A);
    wrReg(1'b0, 32'h0);

    // R3 / R12 sweep: every pin, every mode, rise then fall
    for (int n = 0; n < 8; n++) begin
      for (int m = 0; m < 4; m++) begin
        wrReg(1'b0, 32'(m) << (2*n));
        wrReg(1'b1, 32'h1FF);
        pinIn[n] = 1'b1;
        tick(3);
        checkStatus($sformatf("R3 pin%0d mode%0d rise", n, m), (m & 1) ? (32'h1 << n) : 32'h0);
        wrReg(1'b1, 32'h1FF);
        pinIn[n] = 1'b0;
        tick(3);
        checkStatus($sformatf("R3 pin%0d mode%0d fall", n, m), (m & 2) ? (32'h1 << n) : 32'h0);
      end
    end
    wrReg(1'b1, 32'h1FF);

    // R4 latency
    wrReg(1'b0, (32'd1 << 4) | (32'd1 << 10));
    pinIn[2] = 1'b1;
    tick(2);
    checkStatus("R4 not yet", 32'h0);
    tick(1);
    checkStatus("R4 visible", 32'h4);

    // R5 sticky
    pinIn[2] = 1'b0;
    tick(10);
    checkStatus("R5 held", 32'h4);

    // R6 partial clear
    pinIn[5] = 1'b1;
    tick(3);
    checkStatus("R6 two set", 32'h24);
    wrReg(1'b1, 32'h4);
    checkStatus("R6 one cleared", 32'h20);
    wrReg(1'b1, 32'h0);
    checkStatus("R6 zero write", 32'h20);
    pinIn[5] = 1'b0;
    wrReg(1'b1, 32'h1FF);
    tick(3);

    // R7 set wins over same-cycle clear
    wrReg(1'b0, 32'h3);
    pinIn[0] = 1'b1;
    tick(3);
    checkStatus("R7 first edge", 32'h1);
    pinIn[0] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wrEn = 1'b1; wrSel = 1'b1; wrData = 32'h1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    checkStatus("R7 set kept", 32'h1);
    wrReg(1'b1, 32'h1);
    checkStatus("R7 later clear", 32'h0);

    // R9 / R10 filter on pin 6, both edges
    wrReg(1'b0, (32'd6 << 18) | (32'd3 << 16));
    tick(2);
    wrReg(1'b1, 32'h1FF);
    pinIn[6] = 1'b1;
    tick(FC - 1);
    pinIn[6] = 1'b0;
    tick(FC + 5);
    checkStatus("R10 short pulse dropped", 32'h0);
    pinIn[6] = 1'b1;
    tick(FC + 1);
    checkStatus("R10 before threshold", 32'h0);
    tick(1);
    checkStatus("R10 accepted rise", 32'h100);
    wrReg(1'b1, 32'h1FF);
    pinIn[6] = 1'b0;
    tick(FC + 2);
    checkStatus("R10 accepted fall", 32'h100);
    wrReg(1'b1, 32'h1FF);

    // R9 unselected pin does not reach the filter
    pinIn[5] = 1'b1;
    tick(FC + 5);
    pinIn[5] = 1'b0;
    tick(FC + 5);
    checkStatus("R9 other pin ignored", 32'h0);

    // R9 falling-only filtered mode
    wrReg(1'b0, (32'd6 << 18) | (32'd2 << 16));
    pinIn[6] = 1'b1;
    tick(FC + 5);
    checkStatus("R9 rise ignored in fall mode", 32'h0);
    pinIn[6] = 1'b0;
    tick(FC + 2);
    checkStatus("R9 fall mode hit", 32'h100);
    wrReg(1'b1, 32'h1FF);

    // R12 filtered source disabled
    wrReg(1'b0, (32'd6 << 18));
    pinIn[6] = 1'b1;
    tick(FC + 5);
    pinIn[6] = 1'b0;
    tick(FC + 5);
    checkStatus("R12 filter off", 32'h0);

    // R11 selector switch to a pin at a different level
    wrReg(1'b0, (32'd6 << 18) | (32'd3 << 16));
    pinIn[3] = 1'b1;
    tick(FC + 5);
    wrReg(1'b1, 32'h1FF);
    wrReg(1'b0, (32'd3 << 18) | (32'd3 << 16));
    tick(FC + 5);
    checkStatus("R11 no event on switch", 32'h0);
    pinIn[3] = 1'b0;
    tick(FC + 2);
    checkStatus("R11 new pin filtered", 32'h100);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule